// File: doc/BRIEF.md
# PCM Codec Serial Timeslot Port

This block is the digital serial side of one voice-band PCM codec channel. On the transmit side it takes an 8-bit companded sample from the encoder-side register. It shifts that sample out, most significant bit first, on a serial data line whose output enable is active only during the 8-bit slot. While the slot lasts it also holds an active-low slot indicator low. On the receive side it shifts in 8 serial bits, one on each falling edge of the receive bit clock. It then presents the assembled byte to the decoder side together with a one-cycle valid strobe.

Each direction has its own frame sync. The 8 kHz frame syncs and the bit clocks are treated as slow levels that are already synchronous to the system clock `clk`, and the block finds their edges by comparing each level with its value one cycle earlier. A mode input selects short-frame or long-frame timing. A clock-select input lets the transmit bit clock serve both directions. The block counts only bit-clock edges, so any bit rate from 64 kHz up to 2.048 MHz works with any number of idle bit clocks between frames. Holding the master-clock/power-down input high for `PD_CYCLES` consecutive system clocks forces power-down.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset `dx_oe` is 0, `tslot_n` is 1, `rx_valid` is 0 and `rx_word` is 0.
- R2: Short-frame transmit (`long_frame`=0): a transmit sync is armed when it is sampled high on a falling `tx_bclk` edge after being low on the previous falling edge. The next rising edge drives bit 7 with `dx_oe`=1 and `tslot_n`=0, and each later rising edge drives the next lower bit.
- R3: The rising `tx_bclk` edge that follows the eighth transmit bit sets `dx_oe` to 0 and `tslot_n` to 1. Outside a slot they stay 0 and 1.
- R4: Long-frame transmit (`long_frame`=1): bit 7 is driven at the later of the rise of `tx_fsync` and a rising `tx_bclk` edge seen while `tx_fsync` is high, once for each high period of `tx_fsync`.
- R5: The transmit word is captured from `tx_word` when the slot starts. Changing `tx_word` during the slot does not alter the bits sent.
- R6: Short-frame receive: after an arming falling edge of the receive bit clock (same rule as R2, on `rx_fsync`), the next 8 falling edges sample `rx_din` MSB first. On the eighth, `rx_word` takes the byte and `rx_valid` is 1 for exactly one cycle.
- R7: Long-frame receive: a rise of `rx_fsync` arms the receiver, and the next 8 falling edges of the receive bit clock sample the byte as in R6.
- R8: A new leading frame sync in the middle of a slot drops the partial word and restarts the bit count. No `rx_valid` is raised for the dropped receive word.
- R9: With `clk_sel`=1, `tx_bclk` clocks both directions and `rx_bclk` is ignored. With `clk_sel`=0, the receiver uses only `rx_bclk`.
- R10: When `mclk_pd` has been high for `PD_CYCLES` consecutive clocks, power-down holds `dx_oe`=0 and `tslot_n`=1, raises no `rx_valid` and keeps `rx_word`. A shorter high period has no effect, and the block works again once `mclk_pd` is low.
- R11: Codes pass through unchanged in both directions: 8'h80 (positive full scale), 8'hFF and 8'h7F (zero) and 8'h00 (negative full scale).
- R12: Slot timing depends only on bit-clock and frame-sync edges. Any bit-clock period and any number of idle bit clocks between frames give the same serial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1: `tx_bclk` clocks both directions; 0: each direction has its own bit clock |
| long_frame | input | 1 | 0: short-frame sync timing; 1: long-frame sync timing |
| mclk_pd | input | 1 | Master-clock/power-down level; held high means power-down |
| tx_bclk | input | 1 | Transmit bit clock level |
| tx_fsync | input | 1 | Transmit frame sync level |
| tx_word | input | 8 | Companded transmit sample from the encoder side |
| rx_bclk | input | 1 | Receive bit clock level |
| rx_fsync | input | 1 | Receive frame sync level |
| rx_din | input | 1 | Serial receive data |
| dx_data | output | 1 | Serial transmit data (meaningful while `dx_oe` is 1) |
| dx_oe | output | 1 | Tri-state enable for the transmit data pin |
| tslot_n | output | 1 | Active-low transmit slot indicator (open-drain style enable) |
| rx_word | output | 8 | Last complete received sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
Every output is registered once after the edge detector. A bit-clock or frame-sync edge driven before system clock edge N therefore shows on `dx_data`, `dx_oe`, `tslot_n`, `rx_word` and `rx_valid` right after edge N, and `rx_valid` falls again at edge N+1. Power-down takes effect one cycle after the `PD_CYCLES`-th consecutive high sample of `mclk_pd`. The bench changes inputs on the falling system clock edge and samples outputs at the very next falling edge after each bit-clock transition, which is half a clock after the single register stage. Because of that timing, every transmitted bit and the single `rx_valid` pulse are each seen exactly once.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // direction index used by the per-direction edge detectors
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;
    localparam int NUM_DIR = 2;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_mode_e;

    // previous-cycle levels of one bit clock / frame sync pair
    typedef struct packed {
        logic bclk;
        logic fs;
    } edge_hist_t;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_rise
);

    edge_hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.bclk = bclk;
        hist_d.fs   = fsync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign bclk_rise = bclk & ~hist_q.bclk;
    assign bclk_fall = ~bclk & hist_q.bclk;
    assign fs_rise   = fsync & ~hist_q.fs;

endmodule

// File: rtl/pcm_pd_detect.sv
module pcm_pd_detect #(
    parameter int PD_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_pd,
    output logic pd
);

    localparam int CW = $clog2(PD_CYCLES + 1);
    localparam logic [CW-1:0] PD_MAX = CW'(PD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pd;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        st_d    = st_q;
        cnt_nxt = st_q.cnt;
        if (!mclk_pd) begin
            cnt_nxt = '0;
        end else if (st_q.cnt != PD_MAX) begin
            cnt_nxt = st_q.cnt + 1'b1;
        end
        st_d.cnt = cnt_nxt;
        st_d.pd  = mclk_pd && (cnt_nxt == PD_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd = st_q.pd;

    // R10
    pd_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pd |-> $past(mclk_pd));

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd,
    input  frame_mode_e   mode,
    input  logic          bclk_lvl,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  logic          fsync,
    input  logic          fs_rise,
    input  logic [W-1:0]  word_in,
    output logic          dx_o,
    output logic          oe_o,
    output logic          tslot_n_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             armed;   // short frame: slot starts at next rise
        logic             fs_seen; // short frame: sync level at last fall
        logic             used;    // long frame: slot already started this sync
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      start;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (pd) begin
            st_d = '0;
        end else begin
            if (mode == FRAME_SHORT) begin
                if (bclk_fall) begin
                    st_d.fs_seen = fsync;
                    if (fsync && !st_q.fs_seen) st_d.armed = 1'b1;
                end
                start = bclk_rise && st_q.armed;
            end else begin
                if (!fsync) st_d.used = 1'b0;
                start = (fs_rise && bclk_lvl) ||
                        (bclk_rise && fsync && !st_q.used);
            end

            if (start) begin
                st_d.armed  = 1'b0;
                st_d.used   = 1'b1;
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.sh     = word_in;
            end else if (bclk_rise && st_q.active) begin
                if (st_q.cnt == LAST) begin
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.sh  = {st_q.sh[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dx_o      = st_q.active & st_q.sh[W-1];
    assign oe_o      = st_q.active;
    assign tslot_n_o = ~st_q.active;

    // R3
    tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.active) && !$past(pd)) |-> ($past(st_q.cnt) == LAST));

    // R5
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> ((st_q.cnt == '0) && (st_q.sh == $past(word_in))));

    // R12
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active) && !$past(bclk_rise) && !$past(fs_rise))
        |-> $stable(st_q.cnt));

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd,
    input  frame_mode_e   mode,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  logic          fsync,
    input  logic          fs_rise,
    input  logic          din,
    output logic [W-1:0]  word_o,
    output logic          valid_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             fs_seen;
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
        logic [W-1:0]     word;
        logic             valid;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      arm;
    logic      sample;
    logic [W-1:0] sh_nxt;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        arm        = 1'b0;
        sample     = 1'b0;
        sh_nxt     = {st_q.sh[W-2:0], din};
        if (pd) begin
            st_d.fs_seen = 1'b0;
            st_d.active  = 1'b0;
            st_d.cnt     = '0;
        end else begin
            if (mode == FRAME_SHORT) begin
                if (bclk_fall) begin
                    st_d.fs_seen = fsync;
                    arm    = fsync && !st_q.fs_seen;
                    sample = !arm && st_q.active;
                end
            end else begin
                arm    = fs_rise;
                sample = !fs_rise && bclk_fall && st_q.active;
            end

            if (arm) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end else if (sample) begin
                st_d.sh = sh_nxt;
                if (st_q.cnt == LAST) begin
                    st_d.word   = sh_nxt;
                    st_d.valid  = 1'b1;
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;

    // R6
    rx_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ($past(bclk_fall) && ($past(st_q.cnt) == LAST)));

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R6
    rx_no_rise_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bclk_rise) && !$past(bclk_fall) && !$past(fs_rise) && !$past(pd))
        |-> ($stable(st_q.cnt) && !st_q.valid));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter int W         = 8,
    parameter int PD_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_sel,
    input  logic          long_frame,
    input  logic          mclk_pd,
    input  logic          tx_bclk,
    input  logic          tx_fsync,
    input  logic [W-1:0]  tx_word,
    input  logic          rx_bclk,
    input  logic          rx_fsync,
    input  logic          rx_din,
    output logic          dx_data,
    output logic          dx_oe,
    output logic          tslot_n,
    output logic [W-1:0]  rx_word,
    output logic          rx_valid
);

    frame_mode_e            mode;
    logic                   pd;
    logic [NUM_DIR-1:0]     bclk_in;
    logic [NUM_DIR-1:0]     fs_in;
    logic [NUM_DIR-1:0]     b_rise;
    logic [NUM_DIR-1:0]     b_fall;
    logic [NUM_DIR-1:0]     f_rise;

    assign mode            = frame_mode_e'(long_frame);
    assign bclk_in[DIR_TX] = tx_bclk;
    assign bclk_in[DIR_RX] = clk_sel ? tx_bclk : rx_bclk;
    assign fs_in[DIR_TX]   = tx_fsync;
    assign fs_in[DIR_RX]   = rx_fsync;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        pcm_edge_sync u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .bclk      (bclk_in[g]),
            .fsync     (fs_in[g]),
            .bclk_rise (b_rise[g]),
            .bclk_fall (b_fall[g]),
            .fs_rise   (f_rise[g])
        );
    end

    pcm_pd_detect #(.PD_CYCLES(PD_CYCLES)) u_pd (
        .clk     (clk),
        .rst_n   (rst_n),
        .mclk_pd (mclk_pd),
        .pd      (pd)
    );

    pcm_tx_slot #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd        (pd),
        .mode      (mode),
        .bclk_lvl  (tx_bclk),
        .bclk_rise (b_rise[DIR_TX]),
        .bclk_fall (b_fall[DIR_TX]),
        .fsync     (tx_fsync),
        .fs_rise   (f_rise[DIR_TX]),
        .word_in   (tx_word),
        .dx_o      (dx_data),
        .oe_o      (dx_oe),
        .tslot_n_o (tslot_n)
    );

    pcm_rx_slot #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd        (pd),
        .mode      (mode),
        .bclk_rise (b_rise[DIR_RX]),
        .bclk_fall (b_fall[DIR_RX]),
        .fsync     (rx_fsync),
        .fs_rise   (f_rise[DIR_RX]),
        .din       (rx_din),
        .word_o    (rx_word),
        .valid_o   (rx_valid)
    );

    // R10
    pd_tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (!dx_oe && tslot_n));

    // R10
    pd_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (!rx_valid && $stable(rx_word)));

endmodule

// File: tb/pcm_slot_port_bench.sv
`timescale 1ns/1ps
module pcm_slot_port_bench;

    localparam int PD = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b0;
    logic       long_frame = 1'b0;
    logic       mclk_pd = 1'b0;
    logic       tx_bclk = 1'b0;
    logic       tx_fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       rx_bclk = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_din = 1'b0;
    logic       dx_data, dx_oe, tslot_n, rx_valid;
    logic [7:0] rx_word;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  half_cyc = 3;
    bit  rx_clk_on = 1'b1;
    logic s_dx, s_oe, s_tsn, s_val;
    logic [7:0] s_rxw;

    always #10 clk = ~clk;

    pcm_slot_port #(.W(8), .PD_CYCLES(PD)) u_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .long_frame(long_frame),
        .mclk_pd(mclk_pd), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_word(tx_word),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din),
        .dx_data(dx_data), .dx_oe(dx_oe), .tslot_n(tslot_n),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // one bit period: rise (drive rx data), sample, fall, sample
    task automatic bit_cycle(input logic din);
        tx_bclk = 1'b1;
        if (rx_clk_on) rx_bclk = 1'b1;
        rx_din = din;
        @(negedge clk);
        s_dx = dx_data; s_oe = dx_oe; s_tsn = tslot_n;
        repeat (half_cyc - 1) @(negedge clk);
        tx_bclk = 1'b0;
        rx_bclk = 1'b0;
        @(negedge clk);
        s_val = rx_valid; s_rxw = rx_word;
        repeat (half_cyc - 1) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] txw, input logic [7:0] rxw,
                         input bit tx_live, input bit rx_live, input string tag);
        logic [7:0] got, vword, held;
        int nval;
        bit oe_bad;
        held = rx_word; got = '0; vword = '0; nval = 0; oe_bad = 1'b0;
        tx_word = txw;
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        if (!long_frame) begin
            bit_cycle(1'b0);
            tx_fsync = 1'b0; rx_fsync = 1'b0;
        end
        for (int k = 0; k < 8; k++) begin
            bit_cycle(rxw[7-k]);
            if (k == 0) tx_word = ~txw;
            got[7-k] = s_dx;
            if (s_oe !== tx_live || s_tsn !== !tx_live) oe_bad = 1'b1;
            if (s_val) begin nval++; vword = s_rxw; end
        end
        tx_fsync = 1'b0; rx_fsync = 1'b0;
        bit_cycle(1'b0);
        if (s_val) nval++;
        if (tx_live) begin
            check(got == txw, {tag, " serial word MSB first, latched (R5)"}, got, txw);
            check(!oe_bad, {tag, " dx_oe/tslot_n active all 8 bits"}, oe_bad, 0);
            check(s_oe == 1'b0 && s_tsn == 1'b1, {tag, " R3 release after bit 8"},
                  {s_oe, s_tsn}, 2'b01);
        end else begin
            check(!oe_bad, {tag, " output stays off"}, oe_bad, 0);
        end
        if (rx_live) begin
            check(nval == 1 && vword == rxw, {tag, " receive word"}, {nval[7:0], vword},
                  {8'd1, rxw});
        end else begin
            check(nval == 0 && rx_word == held, {tag, " receive not updated"},
                  {nval[7:0], rx_word}, {8'd0, held});
        end
    endtask

    task automatic test_reset();
        check(dx_oe == 1'b0 && tslot_n == 1'b1 && rx_valid == 1'b0 && rx_word == 8'h00,
              "R1 reset state", {dx_oe, tslot_n, rx_valid, rx_word}, {3'b010, 8'h00});
    endtask

    task automatic test_short();
        long_frame = 1'b0;
        frame(8'hA5, 8'h3C, 1, 1, "R2 R6 short");
        frame(8'h5A, 8'hC3, 1, 1, "R2 R6 short");
    endtask

    task automatic test_long();
        long_frame = 1'b1;
        frame(8'h96, 8'h69, 1, 1, "R4 R7 long");
        frame(8'h0F, 8'hF0, 1, 1, "R4 R7 long");
        long_frame = 1'b0;
    endtask

    task automatic long_align(input bit fs_late);
        logic [7:0] got;
        got = '0;
        long_frame = 1'b1;
        tx_word = 8'hB1;
        if (fs_late) begin
            tx_bclk = 1'b1;
            repeat (2) @(negedge clk);
            check(dx_oe == 1'b0, "R4 no slot before late sync", dx_oe, 0);
            tx_fsync = 1'b1;
            @(negedge clk);
            check(dx_oe == 1'b1 && dx_data == 1'b1, "R4 slot starts on late sync rise",
                  {dx_oe, dx_data}, 2'b11);
            got[7] = dx_data;
            @(negedge clk);
            tx_bclk = 1'b0;
            repeat (half_cyc) @(negedge clk);
            for (int k = 1; k < 8; k++) begin
                bit_cycle(1'b0);
                got[7-k] = s_dx;
            end
        end else begin
            tx_fsync = 1'b1;
            repeat (3) @(negedge clk);
            check(dx_oe == 1'b0, "R4 sync rise with bit clock low waits", dx_oe, 0);
            for (int k = 0; k < 8; k++) begin
                bit_cycle(1'b0);
                got[7-k] = s_dx;
            end
        end
        tx_fsync = 1'b0;
        check(got == 8'hB1, "R4 long aligned word", got, 8'hB1);
        bit_cycle(1'b0);
        check(s_oe == 1'b0, "R3 long release", s_oe, 0);
        long_frame = 1'b0;
    endtask

    task automatic test_restart();
        logic [7:0] got, vword;
        int nval;
        got = '0; vword = '0; nval = 0;
        long_frame = 1'b0;
        tx_word = 8'hE7;
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        bit_cycle(1'b0);
        tx_fsync = 1'b0; rx_fsync = 1'b0;
        for (int k = 0; k < 3; k++) begin
            bit_cycle(1'b1);
            if (s_val) nval++;
        end
        tx_word = 8'h4D;
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        bit_cycle(1'b1);
        if (s_val) nval++;
        tx_fsync = 1'b0; rx_fsync = 1'b0;
        for (int k = 0; k < 8; k++) begin
            bit_cycle(8'h92 >> (7 - k));
            got[7-k] = s_dx;
            if (s_val) begin nval++; vword = s_rxw; end
        end
        bit_cycle(1'b0);
        check(got == 8'h4D, "R8 transmit restarts on new sync", got, 8'h4D);
        check(nval == 1 && vword == 8'h92, "R8 receive restarts, one strobe",
              {nval[7:0], vword}, {8'd1, 8'h92});
    endtask

    task automatic test_clk_sel();
        long_frame = 1'b0;
        clk_sel = 1'b1; rx_clk_on = 1'b0;
        frame(8'h33, 8'hD2, 1, 1, "R9 shared bit clock");
        clk_sel = 1'b0;
        frame(8'hCC, 8'h2D, 1, 0, "R9 separate clock, rx_bclk idle");
        rx_clk_on = 1'b1;
        frame(8'h71, 8'h17, 1, 1, "R9 separate clock");
    endtask

    task automatic test_pd();
        mclk_pd = 1'b1;
        repeat (PD - 2) @(negedge clk);
        mclk_pd = 1'b0;
        @(negedge clk);
        frame(8'h55, 8'hAA, 1, 1, "R10 short high ignored");
        mclk_pd = 1'b1;
        repeat (PD + 2) @(negedge clk);
        check(dx_oe == 1'b0 && tslot_n == 1'b1, "R10 power-down idle", {dx_oe, tslot_n},
              2'b01);
        frame(8'hFF, 8'h11, 0, 0, "R10 power-down");
        mclk_pd = 1'b0;
        repeat (2) @(negedge clk);
        frame(8'h22, 8'h44, 1, 1, "R10 recovery");
    endtask

    task automatic test_codes();
        long_frame = 1'b0;
        frame(8'h80, 8'h80, 1, 1, "R11 +full scale");
        frame(8'hFF, 8'hFF, 1, 1, "R11 zero FF");
        frame(8'h7F, 8'h7F, 1, 1, "R11 zero 7F");
        long_frame = 1'b1;
        frame(8'h00, 8'h00, 1, 1, "R11 -full scale");
        long_frame = 1'b0;
    endtask

    task automatic test_rates();
        bit oe_seen;
        oe_seen = 1'b0;
        half_cyc = 2;
        frame(8'hC9, 8'h9C, 1, 1, "R12 fast bit clock");
        for (int k = 0; k < 20; k++) begin
            bit_cycle(1'b1);
            if (s_oe || !s_tsn || s_val) oe_seen = 1'b1;
        end
        check(!oe_seen, "R12 R3 idle bit clocks leave port off", oe_seen, 0);
        half_cyc = 7;
        frame(8'h3A, 8'hA3, 1, 1, "R12 slow bit clock");
        long_frame = 1'b1;
        frame(8'h6B, 8'hB6, 1, 1, "R12 slow long");
        long_frame = 1'b0;
        half_cyc = 3;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_short();
        test_long();
        long_align(1'b1);
        long_align(1'b0);
        test_restart();
        test_clk_sel();
        test_pd();
        test_codes();
        test_rates();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule